// File: doc/BRIEF.md
# UART with Split Baud Divisor

A byte-oriented serial port for an on-chip register bus. It has one transmit and one receive FIFO, and both sit behind a single data address. A bus write to that address queues a byte for sending. A bus read from it takes the oldest received byte. Frames are 8N1: one low start bit, eight data bits sent least significant first, and one high stop bit. Nothing else is supported.

The bit period is given in reference-clock cycles. The reference clock is 96 MHz, so software writes 96 MHz divided by the baud rate. The divisor is written in two parts. The low six bits go to one write-only register, and the remaining high bits go to another. The serial engines always use the concatenation of the two parts.

A status register reports three things: receive FIFO empty, transmit FIFO full, and a sticky receive-overrun flag. A level interrupt tells software that received data is waiting. Software can clear it through a dedicated register, and it also drops when the receive FIFO is drained.

Top module: `uart_split_div`

## Requirements
- R1: After reset, `txd_o` is high, `irq_o` is low, and a read of the status register (offset 0x18) returns 0x10.
- R2: Offset 0x00 carries data in bits 7:0. A write there queues a byte for transmission. A read there returns the oldest received byte and removes it, so bytes come back in arrival order.
- R3: The transmit FIFO holds 32 bytes. Status bit 5 is 1 while it is full. A data write while it is full is dropped and is never sent.
- R4: Status bit 4 is 1 while the receive FIFO is empty. A data read while it is empty returns 0 and removes nothing.
- R5: The bit period is the divisor in clock cycles. The divisor is {H, L}, where L is bits 5:0 of the last write to offset 0x28 and H is bits 9:0 of the last write to offset 0x24. The divisor must be at least 4.
- R6: Each transmitted frame is a low start bit, then data bits 0 through 7, then a high stop bit. The line is high when no frame is being sent.
- R7: The receiver checks the line half a bit period after a falling edge. If the line is high at that point, the start is rejected and nothing is stored. Otherwise it samples each data bit and the stop bit at their midpoints. A frame is stored only when its stop bit reads high.
- R8: A byte that completes while the receive FIFO holds 32 bytes is discarded. It also sets status bit 6, which stays set until a write to offset 0x44.
- R9: Storing a received byte raises `irq_o`. A write to offset 0x44 lowers it even if data remains. It also drops when the receive FIFO becomes empty. A later stored byte raises it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 96 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| irq_o | output | 1 | Received-data interrupt |

## Verification
Transmit is tried with three divisors: 70 (H=1, L=6), 130 (H=2, L=2) and 16 (H=0, L=16). Each puts a different value in each half of the divisor, so a swapped or mis-shifted half shows up as a wrong measured start-bit length or as misread bytes. The data patterns 0xA5, 0x3C, 0x01, 0x80 and 0x7E separate LSB-first order from MSB-first order and show a stuck data bit. A burst of 34 writes tells a dropped overflow byte apart from one that corrupts the queue.

On the receive side, clean frames are compared against a three-cycle low glitch, which must be rejected. A 33-frame burst separates a discarded overrun byte from one that overwrites the oldest entry. Interleaved interrupt clears and new bytes show that the clear and the drain each lower the interrupt, and that a new byte raises it again.

// File: rtl/uart_split_div_pkg.sv
package uart_split_div_pkg;
  localparam logic [7:0] OFS_DATA = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h18;
  localparam logic [7:0] OFS_DIVH = 8'h24;
  localparam logic [7:0] OFS_DIVL = 8'h28;
  localparam logic [7:0] OFS_ICLR = 8'h44;
  localparam int ST_RXE = 4;
  localparam int ST_TXF = 5;
  localparam int ST_OVR = 6;
  localparam int LO_W   = 6;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/uart_sd_fifo.sv
module uart_sd_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 32   // power of two
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/uart_sd_tx.sv
module uart_sd_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  output logic             busy_o,
  output logic             txd_o
);
  logic [9:0]       sh_q;
  logic [DIV_W-1:0] cnt_q;
  logic [3:0]       nbit_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      nbit_q <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        sh_q   <= {1'b1, data_i, 1'b0};
        cnt_q  <= div_i - DIV_W'(1);
        nbit_q <= '0;
        busy_q <= 1'b1;
      end
    end else if (cnt_q == '0) begin
      cnt_q <= div_i - DIV_W'(1);
      if (nbit_q == 4'd9) begin
        busy_q <= 1'b0;
      end else begin
        sh_q   <= {1'b1, sh_q[9:1]};
        nbit_q <= nbit_q + 4'd1;
      end
    end else begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end
endmodule

// File: rtl/uart_sd_rx.sv
module uart_sd_rx
  import uart_split_div_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rxd_i,
  output logic             valid_o,
  output logic [7:0]       data_o
);
  logic [1:0]       sync_q;
  logic             rx_s;
  rx_state_e        st_q;
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       nbit_q;
  logic [7:0]       sh_q;
  logic             valid_q;

  assign rx_s    = sync_q[1];
  assign valid_o = valid_q;
  assign data_o  = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      nbit_q  <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], rxd_i};
      valid_q <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (!rx_s) begin
          cnt_q <= (div_i >> 1) - DIV_W'(1);
          st_q  <= RX_START;
        end
        RX_START: if (cnt_q != '0) cnt_q <= cnt_q - DIV_W'(1);
          else if (!rx_s) begin
            cnt_q  <= div_i - DIV_W'(1);
            nbit_q <= '0;
            st_q   <= RX_DATA;
          end else st_q <= RX_IDLE;   // glitch
        RX_DATA: if (cnt_q != '0) cnt_q <= cnt_q - DIV_W'(1);
          else begin
            sh_q  <= {rx_s, sh_q[7:1]};
            cnt_q <= div_i - DIV_W'(1);
            if (nbit_q == 3'd7) st_q <= RX_STOP;
            else nbit_q <= nbit_q + 3'd1;
          end
        RX_STOP: if (cnt_q != '0) cnt_q <= cnt_q - DIV_W'(1);
          else begin
            valid_q <= rx_s;
            st_q    <= RX_IDLE;
          end
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_split_div.sv
module uart_split_div
  import uart_split_div_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 32,
  parameter int RESET_DIV  = 833
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        txd_o,
  input  logic        rxd_i,
  output logic        irq_o
);
  localparam int HI_W = DIV_W - LO_W;
  localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(RESET_DIV);

  logic [HI_W-1:0] div_hi_q;
  logic [LO_W-1:0] div_lo_q;
  logic [DIV_W-1:0] div;
  logic wr_data, rd_data, wr_iclr;
  logic tx_full, tx_empty, tx_busy, tx_pop;
  logic [7:0] tx_dout;
  logic rx_full, rx_empty, rx_valid, rx_push;
  logic [7:0] rx_byte, rx_dout;
  logic ovr_q, irq_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[31:HI_W];
  assign div     = {div_hi_q, div_lo_q};
  assign wr_data = wr_i && (addr_i == OFS_DATA);
  assign rd_data = rd_i && (addr_i == OFS_DATA);
  assign wr_iclr = wr_i && (addr_i == OFS_ICLR);
  assign tx_pop  = !tx_busy && !tx_empty;
  assign rx_push = rx_valid && !rx_full;
  assign irq_o   = irq_q && !rx_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_hi_q <= RST_DIV[DIV_W-1:LO_W];
      div_lo_q <= RST_DIV[LO_W-1:0];
      ovr_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_i && addr_i == OFS_DIVH) div_hi_q <= wdata_i[HI_W-1:0];
      if (wr_i && addr_i == OFS_DIVL) div_lo_q <= wdata_i[LO_W-1:0];
      if (rx_valid && rx_full) ovr_q <= 1'b1;
      else if (wr_iclr)        ovr_q <= 1'b0;
      if (rx_push)                  irq_q <= 1'b1;
      else if (wr_iclr || rx_empty) irq_q <= 1'b0;
    end
  end

  uart_sd_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .push_i(wr_data), .data_i(wdata_i[7:0]), .pop_i(tx_pop),
    .data_o(tx_dout), .empty_o(tx_empty), .full_o(tx_full));

  uart_sd_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i, .rst_ni, .div_i(div), .start_i(tx_pop), .data_i(tx_dout),
    .busy_o(tx_busy), .txd_o);

  uart_sd_rx #(.DIV_W(DIV_W)) u_rx (
    .clk_i, .rst_ni, .div_i(div), .rxd_i, .valid_o(rx_valid), .data_o(rx_byte));

  uart_sd_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .push_i(rx_valid), .data_i(rx_byte), .pop_i(rd_data),
    .data_o(rx_dout), .empty_o(rx_empty), .full_o(rx_full));

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_DATA: rdata_o = rx_empty ? 32'h0 : {24'h0, rx_dout};
      OFS_STAT: begin
        rdata_o[ST_RXE] = rx_empty;
        rdata_o[ST_TXF] = tx_full;
        rdata_o[ST_OVR] = ovr_q;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_split_div_chk.sv
module uart_split_div_chk
  import uart_split_div_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic       irq_o,
  input logic       tx_full,
  input logic       tx_pop,
  input logic       rx_empty,
  input logic       rx_full,
  input logic       rx_valid,
  input logic       rx_push,
  input logic       ovr_q
);
  assert_drop_when_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_DATA && tx_full && !tx_pop) |=> tx_full);

  assert_empty_read_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFS_DATA && rx_empty && !rx_push) |=> rx_empty);

  assert_overrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid && rx_full) |=> ovr_q);

  assert_iclr_drops_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_ICLR && !rx_push) |=> !irq_o);

  assert_irq_from_push_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(rx_push));
endmodule

bind uart_split_div uart_split_div_chk u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .irq_o,
  .tx_full, .tx_pop, .rx_empty, .rx_full, .rx_valid, .rx_push, .ovr_q);

// File: tb/uart_split_div_tb.sv
module uart_split_div_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        txd, irq;
  logic        rxd = 1'b1;

  int n_chk = 0, n_fail = 0;
  int bit_div = 833;
  logic [7:0] exp_q [$];
  logic [7:0] mon_b;
  logic [31:0] rv;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_split_div u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .txd_o(txd), .rxd_i(rxd), .irq_o(irq));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic set_div(input int d);
    bus_wr(8'h24, 32'(d >> 6));
    bus_wr(8'h28, 32'(d & 63));
    bit_div = d;
  endtask

  task automatic send_tx(input logic [7:0] b);
    exp_q.push_back(b);
    bus_wr(8'h00, {24'h0, b});
  endtask

  task automatic wait_tx_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2 * bit_div) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b);
    logic [9:0] fr;
    fr = {1'b1, b, 1'b0};
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      rxd = fr[i];
      repeat (bit_div) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor for the serial output
  always begin
    @(negedge txd);
    if (rst_n) begin
      repeat (bit_div / 2) @(posedge clk);
      #2 check(txd == 1'b0, "R6 start bit", 32'(txd), 32'h0);
      for (int i = 0; i < 8; i++) begin
        repeat (bit_div) @(posedge clk);
        #2 mon_b[i] = txd;
      end
      repeat (bit_div) @(posedge clk);
      #2 check(txd == 1'b1, "R6 stop bit", 32'(txd), 32'h1);
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected byte", 32'(mon_b), 32'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(mon_b == e, "R6 tx byte", 32'(mon_b), 32'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #1 check(txd == 1'b1, "R1 txd idle", 32'(txd), 32'h1);
    check(irq == 1'b0, "R1 irq low", 32'(irq), 32'h0);
    rst_n = 1'b1;
    bus_rd(8'h18, rv);
    check(rv == 32'h10, "R1 status reset", rv, 32'h10);
    bus_rd(8'h00, rv);
    check(rv == 32'h0, "R4 empty read zero", rv, 32'h0);

    // R5: divisor 70 = {1, 6}; start bit must last 70 cycles
    set_div(70);
    send_tx(8'hA5);
    @(negedge txd);
    n = 0;
    @(negedge clk);
    while (txd == 1'b0) begin n++; @(negedge clk); end
    check(n == 70, "R5 bit period 70", 32'(n), 32'd70);
    send_tx(8'h3C);
    send_tx(8'h01);
    wait_tx_idle();

    // R5: divisor 130 = {2, 2}
    set_div(130);
    send_tx(8'h80);
    send_tx(8'h7E);
    wait_tx_idle();

    // R3: 34 writes, the last is dropped
    set_div(16);
    for (int i = 0; i < 33; i++) send_tx(8'(8'h10 + i));
    bus_rd(8'h18, rv);
    check(rv[5] == 1'b1, "R3 tx full flag", 32'(rv[5]), 32'h1);
    bus_wr(8'h00, 32'hEE);
    wait_tx_idle();
    bus_rd(8'h18, rv);
    check(rv[5] == 1'b0, "R3 tx full cleared", 32'(rv[5]), 32'h0);

    // R7/R9: receive one byte
    send_rx(8'h5A);
    check(irq == 1'b1, "R9 irq on data", 32'(irq), 32'h1);
    bus_rd(8'h18, rv);
    check(rv[4] == 1'b0, "R4 rx not empty", 32'(rv[4]), 32'h0);
    bus_rd(8'h00, rv);
    check(rv == 32'h5A, "R7 rx byte", rv, 32'h5A);
    #1 check(irq == 1'b0, "R9 irq drop on drain", 32'(irq), 32'h0);
    bus_rd(8'h18, rv);
    check(rv[4] == 1'b1, "R4 rx empty again", 32'(rv[4]), 32'h1);

    // R7: glitch shorter than half a bit
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk); rxd = 1'b1;
    repeat (40) @(negedge clk);
    bus_rd(8'h18, rv);
    check(rv[4] == 1'b1, "R7 glitch rejected", 32'(rv[4]), 32'h1);
    send_rx(8'hC3);
    bus_rd(8'h00, rv);
    check(rv == 32'hC3, "R7 byte after glitch", rv, 32'hC3);

    // R9: clear with data still queued, re-raise on new byte
    send_rx(8'h11);
    send_rx(8'h22);
    bus_wr(8'h44, 32'h1);
    #1 check(irq == 1'b0, "R9 irq cleared", 32'(irq), 32'h0);
    send_rx(8'h33);
    check(irq == 1'b1, "R9 irq re-raised", 32'(irq), 32'h1);
    bus_rd(8'h00, rv); check(rv == 32'h11, "R2 order 1", rv, 32'h11);
    bus_rd(8'h00, rv); check(rv == 32'h22, "R2 order 2", rv, 32'h22);
    bus_rd(8'h00, rv); check(rv == 32'h33, "R2 order 3", rv, 32'h33);
    #1 check(irq == 1'b0, "R9 irq after drain", 32'(irq), 32'h0);

    // R8: overrun
    for (int i = 0; i < 33; i++) send_rx(8'(8'h40 + i));
    bus_rd(8'h18, rv);
    check(rv[6] == 1'b1, "R8 overrun set", 32'(rv[6]), 32'h1);
    for (int i = 0; i < 32; i++) begin
      bus_rd(8'h00, rv);
      check(rv == 32'(8'h40 + i), "R8 kept byte", rv, 32'(8'h40 + i));
    end
    bus_rd(8'h00, rv);
    check(rv == 32'h0, "R4 empty read after overrun", rv, 32'h0);
    bus_rd(8'h18, rv);
    check(rv == 32'h50, "R8 overrun sticky", rv, 32'h50);
    bus_wr(8'h44, 32'h1);
    bus_rd(8'h18, rv);
    check(rv == 32'h10, "R8 overrun cleared", rv, 32'h10);

    check(exp_q.size() == 0, "R6 queue drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule